// File: doc/BRIEF.md
# Floating-Point Min/Max Unit

This unit returns the smaller or the larger of two floating-point operands held in 64-bit register values. It handles half, single and double precision. Each operand is decoded in the chosen format: NaNs are found, signaling NaNs raise an invalid-operation flag, and negative zero is ordered below positive zero. A lone NaN operand is passed over in favour of the other operand. Two NaNs give the canonical quiet NaN of the format.

A narrow operand must arrive NaN-boxed, with every bit above its width set to one. If it does not, it is read as the canonical NaN of its format. A narrow result is always written back NaN-boxed. The result and the flag are registered and appear one cycle after the input strobe, together with an output valid.

Top module: `fp_minmax_unit`

## Requirements
- R1: `out_valid` is high in exactly the cycles that follow a cycle with `in_valid` high. A synchronous reset clears `out_valid`, `result` and `invalid` to zero.
- R2: `fmt_code` 5'h14 selects single, 5'h15 selects double and 5'h16 selects half. Any other code is handled as double. `op_sel` 0 selects minimum and 1 selects maximum.
- R3: For minimum, operand A is returned when A < B by quiet comparison, or when A == B and A's sign bit is set. Otherwise operand B is returned.
- R4: For maximum, operand A is returned when B < A by quiet comparison, or when A == B and B's sign bit is set. Otherwise operand B is returned.
- R5: -0 orders below +0. Minimum of the two zeros gives -0 and maximum gives +0, in either operand order.
- R6: When exactly one operand is a NaN (exponent all ones, mantissa nonzero), the result is the other operand.
- R7: When both operands are NaN, the result is the canonical quiet NaN. This is 16'h7E00 for half, 32'h7FC00000 for single and 64'h7FF8000000000000 for double.
- R8: A half result has bits 63:16 set to one, and a single result has bits 63:32 set to one.
- R9: A half or single operand whose upper register bits are not all ones is treated as the canonical NaN of that format.
- R10: `invalid` is set when either operand is a signaling NaN (mantissa nonzero, top mantissa bit clear). The selected result is unchanged by this flag.
- R11: While `in_valid` is low, `result` and `invalid` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation strobe |
| fmt_code | input | 5 | Format function code |
| op_sel | input | 1 | 0 = minimum, 1 = maximum |
| src_a | input | 64 | Operand A register value |
| src_b | input | 64 | Operand B register value |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| result | output | 64 | Selected value, NaN-boxed for narrow formats |
| invalid | output | 1 | Invalid-operation flag |

## Verification
On every cycle, the assertions check the one-cycle valid timing, the hold of the result while idle, and NaN-boxing of narrow results. For double operands they also check the canonical NaN for two NaNs, the pass-over of a lone NaN in B, and the signaling-NaN flag. The directed and random scenarios of the bench show the rest: the numeric ordering of minimum and maximum in every format, the signed-zero tie-breaks, improperly boxed inputs read as NaN, and the fallback of unknown format codes to double.

// File: rtl/fpmm_pkg.sv
package fpmm_pkg;

    localparam int unsigned XLEN = 64;

    localparam int unsigned H_EXP = 5;
    localparam int unsigned H_MAN = 10;
    localparam int unsigned S_EXP = 8;
    localparam int unsigned S_MAN = 23;
    localparam int unsigned D_EXP = 11;
    localparam int unsigned D_MAN = 52;
    localparam int unsigned H_W   = 1 + H_EXP + H_MAN;
    localparam int unsigned S_W   = 1 + S_EXP + S_MAN;
    localparam int unsigned D_W   = 1 + D_EXP + D_MAN;

    localparam logic [4:0] FUNC_SINGLE = 5'h14;
    localparam logic [4:0] FUNC_DOUBLE = 5'h15;
    localparam logic [4:0] FUNC_HALF   = 5'h16;

    localparam logic [XLEN-1:0] CANON_H = 64'h0000_0000_0000_7E00;
    localparam logic [XLEN-1:0] CANON_S = 64'h0000_0000_7FC0_0000;
    localparam logic [XLEN-1:0] CANON_D = 64'h7FF8_0000_0000_0000;

    typedef enum logic [1:0] {
        FMT_HALF   = 2'd0,
        FMT_SINGLE = 2'd1,
        FMT_DOUBLE = 2'd2
    } fmt_e;

    typedef struct packed {
        logic [XLEN-1:0] value;
        logic            sign;
        logic [XLEN-2:0] mag;
        logic            zero;
        logic            nan;
        logic            snan;
    } opnd_t;

    typedef struct packed {
        logic            vld;
        logic [XLEN-1:0] data;
        logic            nv;
    } out_state_t;

    function automatic fmt_e decode_fmt(input logic [4:0] code);
        fmt_e f;
        case (code)
            FUNC_HALF:   f = FMT_HALF;
            FUNC_SINGLE: f = FMT_SINGLE;
            default:     f = FMT_DOUBLE;
        endcase
        return f;
    endfunction

    function automatic logic [XLEN-1:0] canon_nan(input fmt_e f);
        logic [XLEN-1:0] c;
        case (f)
            FMT_HALF:   c = CANON_H;
            FMT_SINGLE: c = CANON_S;
            default:    c = CANON_D;
        endcase
        return c;
    endfunction

    function automatic logic [XLEN-1:0] nan_box(input logic [XLEN-1:0] v, input fmt_e f);
        logic [XLEN-1:0] r;
        case (f)
            FMT_HALF:   r = {{(XLEN-H_W){1'b1}}, v[H_W-1:0]};
            FMT_SINGLE: r = {{(XLEN-S_W){1'b1}}, v[S_W-1:0]};
            default:    r = v;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/fpmm_operand.sv
module fpmm_operand
    import fpmm_pkg::*;
(
    input  logic [XLEN-1:0] src_i,
    input  fmt_e            fmt_i,
    output opnd_t           opnd_o
);

    localparam int unsigned H_PAD = XLEN - H_W;
    localparam int unsigned S_PAD = XLEN - S_W;

    logic [XLEN-1:0] val;
    logic            exp_ones;
    logic            man_nz;
    logic            man_top;

    always_comb begin
        val      = src_i;
        exp_ones = 1'b0;
        man_nz   = 1'b0;
        man_top  = 1'b0;
        opnd_o   = '0;
        case (fmt_i)
            FMT_HALF: begin
                val = (&src_i[XLEN-1:H_W]) ? {{H_PAD{1'b0}}, src_i[H_W-1:0]} : CANON_H;
                exp_ones     = &val[H_W-2 -: H_EXP];
                man_nz       = |val[H_MAN-1:0];
                man_top      = val[H_MAN-1];
                opnd_o.sign  = val[H_W-1];
                opnd_o.mag   = {{H_PAD{1'b0}}, val[H_W-2:0]};
            end
            FMT_SINGLE: begin
                val = (&src_i[XLEN-1:S_W]) ? {{S_PAD{1'b0}}, src_i[S_W-1:0]} : CANON_S;
                exp_ones     = &val[S_W-2 -: S_EXP];
                man_nz       = |val[S_MAN-1:0];
                man_top      = val[S_MAN-1];
                opnd_o.sign  = val[S_W-1];
                opnd_o.mag   = {{S_PAD{1'b0}}, val[S_W-2:0]};
            end
            default: begin
                val          = src_i;
                exp_ones     = &val[D_W-2 -: D_EXP];
                man_nz       = |val[D_MAN-1:0];
                man_top      = val[D_MAN-1];
                opnd_o.sign  = val[D_W-1];
                opnd_o.mag   = val[D_W-2:0];
            end
        endcase
        opnd_o.value = val;
        opnd_o.zero  = (opnd_o.mag == '0);
        opnd_o.nan   = exp_ones && man_nz;
        opnd_o.snan  = exp_ones && man_nz && !man_top;
    end

endmodule

// File: rtl/fpmm_order.sv
module fpmm_order
    import fpmm_pkg::*;
(
    input  opnd_t x_i,
    input  opnd_t y_i,
    output logic  lt_o,
    output logic  eq_o
);

    logic unordered;
    logic both_zero;

    always_comb begin
        unordered = x_i.nan || y_i.nan;
        both_zero = x_i.zero && y_i.zero;
        eq_o = !unordered &&
               (both_zero || ((x_i.sign == y_i.sign) && (x_i.mag == y_i.mag)));
        if (unordered || both_zero) begin
            lt_o = 1'b0;
        end else if (x_i.sign != y_i.sign) begin
            lt_o = x_i.sign;
        end else if (x_i.sign) begin
            lt_o = x_i.mag > y_i.mag;
        end else begin
            lt_o = x_i.mag < y_i.mag;
        end
    end

endmodule

// File: rtl/fp_minmax_unit.sv
module fp_minmax_unit
    import fpmm_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [4:0]      fmt_code,
    input  logic            op_sel,
    input  logic [63:0]     src_a,
    input  logic [63:0]     src_b,
    output logic            out_valid,
    output logic [63:0]     result,
    output logic            invalid
);

    localparam int unsigned N_OPND = 2;

    fmt_e            fmt;
    logic [XLEN-1:0] src   [N_OPND];
    opnd_t           opnd  [N_OPND];
    logic            lt_ab, eq_ab, lt_ba, eq_ba;
    logic            pick_a;
    logic [XLEN-1:0] chosen;
    out_state_t      state_d, state_q;

    assign fmt    = decode_fmt(fmt_code);
    assign src[0] = src_a;
    assign src[1] = src_b;

    for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
        fpmm_operand u_opnd (
            .src_i  (src[g]),
            .fmt_i  (fmt),
            .opnd_o (opnd[g])
        );
    end

    fpmm_order u_ord_ab (
        .x_i  (opnd[0]),
        .y_i  (opnd[1]),
        .lt_o (lt_ab),
        .eq_o (eq_ab)
    );

    fpmm_order u_ord_ba (
        .x_i  (opnd[1]),
        .y_i  (opnd[0]),
        .lt_o (lt_ba),
        .eq_o (eq_ba)
    );

    always_comb begin
        state_d     = state_q;
        state_d.vld = in_valid;
        if (op_sel) begin
            pick_a = lt_ba || (eq_ba && opnd[1].sign);
        end else begin
            pick_a = lt_ab || (eq_ab && opnd[0].sign);
        end
        pick_a = pick_a || opnd[1].nan;
        if (opnd[0].nan && opnd[1].nan) begin
            chosen = canon_nan(fmt);
        end else if (pick_a) begin
            chosen = opnd[0].value;
        end else begin
            chosen = opnd[1].value;
        end
        if (in_valid) begin
            state_d.data = nan_box(chosen, fmt);
            state_d.nv   = opnd[0].snan || opnd[1].snan;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid = state_q.vld;
    assign result    = state_q.data;
    assign invalid   = state_q.nv;

endmodule

// File: rtl/fpmm_checker.sv
module fpmm_checker (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [4:0]  fmt_code,
    input logic        op_sel,
    input logic [63:0] src_a,
    input logic [63:0] src_b,
    input logic        out_valid,
    input logic [63:0] result,
    input logic        invalid
);

    logic dbl, a_nan, b_nan, a_snan, b_snan;

    assign dbl    = (fmt_code != 5'h14) && (fmt_code != 5'h16);
    assign a_nan  = (src_a[62:52] == 11'h7FF) && (src_a[51:0] != 52'd0);
    assign b_nan  = (src_b[62:52] == 11'h7FF) && (src_b[51:0] != 52'd0);
    assign a_snan = a_nan && !src_a[51];
    assign b_snan = b_nan && !src_b[51];

    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    // R1
    valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(result) && $stable(invalid)));
    // R8
    half_box_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && fmt_code == 5'h16) |=> (&result[63:16]));
    // R8
    single_box_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && fmt_code == 5'h14) |=> (&result[63:32]));
    // R7
    dbl_canon_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && dbl && a_nan && b_nan) |=> (result == 64'h7FF8_0000_0000_0000));
    // R6
    dbl_lone_nan_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && dbl && b_nan && !a_nan) |=> (result == $past(src_a)));
    // R10
    dbl_snan_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && dbl && (a_snan || b_snan)) |=> invalid);
    // R10
    dbl_no_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && dbl && !a_nan && !b_nan) |=> !invalid);

endmodule

bind fp_minmax_unit fpmm_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .fmt_code  (fmt_code),
    .op_sel    (op_sel),
    .src_a     (src_a),
    .src_b     (src_b),
    .out_valid (out_valid),
    .result    (result),
    .invalid   (invalid)
);

// File: tb/fp_minmax_unit_test.sv
module fp_minmax_unit_test;

    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 400;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [4:0]  fmt_code = 5'h15;
    logic        op_sel = 1'b0;
    logic [63:0] src_a = '0;
    logic [63:0] src_b = '0;
    logic        out_valid;
    logic [63:0] result;
    logic        invalid;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    fp_minmax_unit uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .fmt_code(fmt_code),
        .op_sel(op_sel), .src_a(src_a), .src_b(src_b),
        .out_valid(out_valid), .result(result), .invalid(invalid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // format index: 0 half, 1 single, 2 double
    function automatic int fidx(input logic [4:0] c);
        if (c == 5'h16) return 0;
        if (c == 5'h14) return 1;
        return 2;
    endfunction

    function automatic int fwidth(input int f);
        return (f == 0) ? 16 : (f == 1) ? 32 : 64;
    endfunction

    function automatic int fman(input int f);
        return (f == 0) ? 10 : (f == 1) ? 23 : 52;
    endfunction

    function automatic logic [63:0] fcanon(input int f);
        return (f == 0) ? 64'h7E00 : (f == 1) ? 64'h7FC0_0000 : 64'h7FF8_0000_0000_0000;
    endfunction

    function automatic logic [63:0] low_mask(input int w);
        return (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    endfunction

    function automatic logic [63:0] unbox(input logic [63:0] v, input int f);
        int w = fwidth(f);
        if (w == 64) return v;
        if ((v | low_mask(w)) == '1) return v & low_mask(w);
        return fcanon(f);
    endfunction

    function automatic bit is_nan(input logic [63:0] v, input int f);
        int m = fman(f);
        int w = fwidth(f);
        logic [63:0] e = (v >> m) & low_mask(w - 1 - m);
        return (e == low_mask(w - 1 - m)) && ((v & low_mask(m)) != 0);
    endfunction

    function automatic bit is_snan(input logic [63:0] v, input int f);
        return is_nan(v, f) && !v[fman(f)-1];
    endfunction

    function automatic logic signed [65:0] okey(input logic [63:0] v, input int f);
        int w = fwidth(f);
        logic [63:0] mag = v & low_mask(w - 1);
        logic signed [65:0] k = $signed({2'b00, mag});
        return v[w-1] ? -k : k;
    endfunction

    function automatic logic [63:0] box(input logic [63:0] v, input int f);
        int w = fwidth(f);
        return (w == 64) ? v : (v | ~low_mask(w));
    endfunction

    function automatic logic [63:0] model(input logic [63:0] a_raw, input logic [63:0] b_raw,
                                          input logic [4:0] code, input logic mx);
        int f = fidx(code);
        int w = fwidth(f);
        logic [63:0] a = unbox(a_raw, f);
        logic [63:0] b = unbox(b_raw, f);
        logic [63:0] r;
        logic signed [65:0] ka = okey(a, f);
        logic signed [65:0] kb = okey(b, f);
        if (is_nan(a, f) && is_nan(b, f)) r = fcanon(f);
        else if (is_nan(b, f)) r = a;
        else if (is_nan(a, f)) r = b;
        else if (ka < kb) r = mx ? b : a;
        else if (kb < ka) r = mx ? a : b;
        else if (!mx) r = a[w-1] ? a : b;
        else r = b[w-1] ? a : b;
        return box(r, f);
    endfunction

    function automatic bit model_nv(input logic [63:0] a_raw, input logic [63:0] b_raw,
                                    input logic [4:0] code);
        int f = fidx(code);
        return is_snan(unbox(a_raw, f), f) || is_snan(unbox(b_raw, f), f);
    endfunction

    task automatic check64(input string req, input string what,
                           input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic run_op(input string req, input logic [63:0] a, input logic [63:0] b,
                          input logic [4:0] code, input logic mx);
        @(negedge clk);
        in_valid = 1'b1; src_a = a; src_b = b; fmt_code = code; op_sel = mx;
        @(negedge clk);
        in_valid = 1'b0;
        check64("R1", "out_valid", {63'd0, out_valid}, 64'd1);
        check64(req, "result", result, model(a, b, code, mx));
        check64(req, "invalid", {63'd0, invalid}, {63'd0, model_nv(a, b, code)});
    endtask

    function automatic logic [63:0] gen(input int f);
        int w = fwidth(f);
        int m = fman(f);
        logic [63:0] sgn = 64'd1 << (w - 1);
        logic [63:0] expm = low_mask(w - 1 - m) << m;
        logic [63:0] v;
        case ($urandom % 8)
            0: v = 64'd0;
            1: v = sgn;
            2: v = expm | (64'd1 << (m - 1));
            3: v = expm | 64'd1;
            4: v = expm | (($urandom % 2) != 0 ? sgn : 64'd0);
            5: v = {32'd0, $urandom} & low_mask(m);
            default: v = {$urandom, $urandom};
        endcase
        v = v & low_mask(w);
        if (w < 64 && ($urandom % 12) != 0) v = box(v, f);
        else if (w < 64) v = v | ({$urandom, $urandom} & ~low_mask(w) & 64'h7FFF_FFFF_FFFF_FFFF);
        return v;
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] held;
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check64("R1", "reset out_valid", {63'd0, out_valid}, 64'd0);
        check64("R1", "reset result", result, 64'd0);
        check64("R1", "reset invalid", {63'd0, invalid}, 64'd0);

        // R3 R4 ordinary doubles
        run_op("R3", 64'h3FF0_0000_0000_0000, 64'h4000_0000_0000_0000, 5'h15, 1'b0);
        run_op("R4", 64'h3FF0_0000_0000_0000, 64'h4000_0000_0000_0000, 5'h15, 1'b1);
        run_op("R3", 64'hBFF0_0000_0000_0000, 64'hC000_0000_0000_0000, 5'h15, 1'b0);
        run_op("R4", 64'hBFF0_0000_0000_0000, 64'h3FF0_0000_0000_0000, 5'h15, 1'b1);
        // R5 signed zeros both orders, min and max
        run_op("R5", 64'h8000_0000_0000_0000, 64'h0, 5'h15, 1'b0);
        run_op("R5", 64'h0, 64'h8000_0000_0000_0000, 5'h15, 1'b0);
        run_op("R5", 64'h8000_0000_0000_0000, 64'h0, 5'h15, 1'b1);
        run_op("R5", 64'h0, 64'h8000_0000_0000_0000, 5'h15, 1'b1);
        run_op("R5", 64'hFFFF_FFFF_FFFF_8000, 64'hFFFF_FFFF_FFFF_0000, 5'h16, 1'b0);
        // R6 lone NaN in either position
        run_op("R6", 64'h7FF8_0000_0000_0000, 64'h4000_0000_0000_0000, 5'h15, 1'b0);
        run_op("R6", 64'h4000_0000_0000_0000, 64'h7FF8_0000_0000_0001, 5'h15, 1'b1);
        run_op("R6", 64'hFFFF_FFFF_7FC0_0001, 64'hFFFF_FFFF_BF80_0000, 5'h14, 1'b1);
        // R7 both NaN per format
        run_op("R7", 64'hFFF8_0000_0000_0005, 64'h7FF4_0000_0000_0000, 5'h15, 1'b0);
        run_op("R7", 64'hFFFF_FFFF_FFC0_0003, 64'hFFFF_FFFF_7F80_0001, 5'h14, 1'b1);
        run_op("R7", 64'hFFFF_FFFF_FFFF_FE01, 64'hFFFF_FFFF_FFFF_7C01, 5'h16, 1'b0);
        // R8 boxing of narrow results
        run_op("R8", 64'hFFFF_FFFF_3F80_0000, 64'hFFFF_FFFF_4000_0000, 5'h14, 1'b0);
        run_op("R8", 64'hFFFF_FFFF_FFFF_3C00, 64'hFFFF_FFFF_FFFF_4000, 5'h16, 1'b1);
        // R9 improperly boxed inputs
        run_op("R9", 64'h0000_0000_3F80_0000, 64'hFFFF_FFFF_4000_0000, 5'h14, 1'b1);
        run_op("R9", 64'hFFFF_FFFF_FFFF_3C00, 64'h0000_FFFF_FFFF_4000, 5'h16, 1'b0);
        run_op("R9", 64'h1234_0000_0000_3C00, 64'h0000_0000_0000_4000, 5'h16, 1'b0);
        // R10 signaling NaN flag, selection unaffected
        run_op("R10", 64'h7FF0_0000_0000_0001, 64'h3FF0_0000_0000_0000, 5'h15, 1'b0);
        run_op("R10", 64'hFFFF_FFFF_3F80_0000, 64'hFFFF_FFFF_7F80_0001, 5'h14, 1'b1);
        run_op("R10", 64'hFFFF_FFFF_FFFF_7C01, 64'hFFFF_FFFF_FFFF_BC00, 5'h16, 1'b0);
        // R2 unknown code handled as double
        run_op("R2", 64'hFFFF_FFFF_3F80_0000, 64'hFFFF_FFFF_4000_0000, 5'h17, 1'b0);
        run_op("R2", 64'h3FF0_0000_0000_0000, 64'h4000_0000_0000_0000, 5'h00, 1'b1);

        // R11 hold while idle
        held = result;
        @(negedge clk);
        src_a = 64'h0; src_b = 64'h7FF0_0000_0000_0001; op_sel = 1'b1;
        @(negedge clk);
        check64("R11", "held result", result, held);
        check64("R11", "held invalid", {63'd0, invalid}, 64'd0);
        check64("R1", "idle out_valid", {63'd0, out_valid}, 64'd0);

        // random mix
        for (int i = 0; i < N_RANDOM; i++) begin
            int sel = $urandom % 3;
            logic [4:0] code = (sel == 0) ? 5'h16 : (sel == 1) ? 5'h14 : 5'h15;
            logic mx = ($urandom % 2) != 0;
            logic [63:0] a = gen(fidx(code));
            logic [63:0] b = (($urandom % 6) == 0) ? a : gen(fidx(code));
            run_op(mx ? "R4" : "R3", a, b, code, mx);
        end

        // R1 synchronous reset clears valid mid-stream
        @(negedge clk);
        in_valid = 1'b1;
        rst = 1'b1;
        @(negedge clk);
        check64("R1", "reset during valid", {63'd0, out_valid}, 64'd0);
        rst = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule